// File: doc/BRIEF.md
# Wide-vector warm-up dispatch throttle

This block is a per-core controller that tracks the power state of the wide vector datapath and holds back instruction dispatch while that datapath is coming up. After a long quiet spell the datapath is cold. The first operation whose effective destination width is 256 bits or more starts a fixed warm-up period. When that period ends, the datapath counts as warm. It falls back to cold once no wide operation has been seen for an idle interval set by a parameter.

During warm-up, any instruction that writes a vector register opens a throttle window. This includes 128-bit and scalar floating-point writes. The window also covers the general-purpose instructions that follow the write. Inside the window the block lets dispatch through on only one cycle in every few. Outside the window, and in the cold and warm states, dispatch runs at full rate.

The block looks at one dispatch slot per cycle. For that slot it takes a valid bit, a vector-write flag and the effective width, which a separate widening tracker supplies. It returns a registered dispatch enable and the current state. The warm-up period, the idle interval, the throttle window length and the throttle ratio are all parameters counted in core clock cycles.

Top module: `vwarm_throttle`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `phase_state` is 0 (cold) and `dispatch_en` is 1.
- R2: Width codes on `slot_width` are 0 = none or scalar, 1 = 128-bit, 2 = 256-bit and 3 = 512-bit. In cold, a valid slot with code 2 or 3 moves `phase_state` to 1 (transition) on the next cycle. Codes 0 and 1 leave the state cold, and so does any slot with `slot_valid` low.
- R3: `phase_state` stays 1 for exactly WARMUP_CYCLES cycles and then reads 2 (warm). It never goes straight from 0 to 2.
- R4: The state falls from warm to 0 once IDLE_CYCLES consecutive cycles have passed with no valid wide slot (code 2 or 3). The count runs from the last such slot. A wide slot in transition or warm restarts the count.
- R5: In transition, a valid slot with `slot_vec_wr` high or a wide code starts a throttle window of THROTTLE_SPAN cycles. The window starts on the next cycle, whatever the slot's width. The slot that causes the cold-to-transition move does not throttle.
- R6: Inside a window, `dispatch_en` is high on exactly one cycle in every THROTTLE_RATIO cycles. A window that starts from the unthrottled state shows RATIO-1 low cycles and then one high cycle, repeated.
- R7: A new trigger inside an open window restarts the window at THROTTLE_SPAN cycles and keeps the skip pattern's phase.
- R8: Outside a window, `dispatch_en` is 1. This covers cold, warm, and transition with only general-purpose slots. A slot with `slot_valid` low never opens a window.
- R9: Entering warm closes any open window at once, so `dispatch_en` is 1 on the first warm cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_valid | input | 1 | Dispatch slot holds an instruction |
| slot_vec_wr | input | 1 | Slot instruction writes a vector register |
| slot_width | input | 2 | Effective destination width code (0 none, 1 128, 2 256, 3 512) |
| dispatch_en | output | 1 | Registered dispatch permission for the current cycle |
| phase_state | output | 2 | Datapath state: 0 cold, 1 transition, 2 warm |

## Verification
The table-driven part runs in cold with invalid slots, narrow vector writes, scalar writes and general-purpose slots. This separates the true wake condition from the look-alike inputs. It then runs in transition with general-purpose slots, scalar and 128-bit writes, and a retrigger in the middle of a window. This separates the shadow-only throttling from full-rate dispatch, and the phase-keeping restart from a fresh start. The directed tests then check the following: a window cut short at the warm boundary, the 512-bit code, reset in the middle of a window, and the idle interval both with and without a restarting wide slot, each sampled on the cycle before and the cycle of the expected change.

// File: rtl/vwt_pkg.sv
package vwt_pkg;
  typedef enum logic [1:0] {
    PH_COLD  = 2'd0,
    PH_TRANS = 2'd1,
    PH_WARM  = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    VW_NONE = 2'd0,
    VW_128  = 2'd1,
    VW_256  = 2'd2,
    VW_512  = 2'd3
  } vwidth_t;

  function automatic logic is_wide(input logic [1:0] w);
    return (w == VW_256) || (w == VW_512);
  endfunction
endpackage

// File: rtl/vwt_phase_fsm.sv
module vwt_phase_fsm
  import vwt_pkg::*;
#(
  parameter int WARMUP_CYCLES = 56000,
  parameter int IDLE_CYCLES   = 2700000
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wide_seen,
  output phase_t phase_q,
  output phase_t phase_d
);
  localparam int WW = (WARMUP_CYCLES > 1) ? $clog2(WARMUP_CYCLES) : 1;
  localparam int IW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [WW-1:0] WARM_LAST = WW'(WARMUP_CYCLES - 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYCLES - 1);

  logic [WW-1:0] warm_cnt_q, warm_cnt_d;
  logic [IW-1:0] idle_cnt_q, idle_cnt_d;
  logic          warm_done, idle_done;

  assign warm_done = (warm_cnt_q >= WARM_LAST);
  assign idle_done = (idle_cnt_q >= IDLE_LAST);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_COLD:  if (wide_seen) phase_d = PH_TRANS;
      PH_TRANS: if (warm_done) phase_d = PH_WARM;
      PH_WARM:  if (!wide_seen && idle_done) phase_d = PH_COLD;
      default:  phase_d = PH_COLD;
    endcase
  end

  always_comb begin
    warm_cnt_d = '0;
    if (phase_q == PH_TRANS && phase_d == PH_TRANS) warm_cnt_d = warm_cnt_q + 1'b1;
  end

  always_comb begin
    if (wide_seen || phase_d == PH_COLD) idle_cnt_d = '0;
    else if (idle_done)                  idle_cnt_d = idle_cnt_q;
    else                                 idle_cnt_d = idle_cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_COLD;
      warm_cnt_q <= '0;
      idle_cnt_q <= '0;
    end else begin
      phase_q    <= phase_d;
      warm_cnt_q <= warm_cnt_d;
      idle_cnt_q <= idle_cnt_d;
    end
  end
endmodule

// File: rtl/vwt_shadow.sv
module vwt_shadow
  import vwt_pkg::*;
#(
  parameter int THROTTLE_SPAN = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   trigger,
  input  phase_t phase_d,
  output logic   active_q,
  output logic   active_d
);
  localparam int SW = $clog2(THROTTLE_SPAN + 1);
  localparam logic [SW-1:0] SPAN = SW'(THROTTLE_SPAN);

  logic [SW-1:0] left_q, left_d;

  always_comb begin
    if (phase_d != PH_TRANS) left_d = '0;
    else if (trigger)        left_d = SPAN;
    else if (left_q != '0)   left_d = left_q - 1'b1;
    else                     left_d = '0;
  end

  assign active_d = (left_d != '0);
  assign active_q = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) left_q <= '0;
    else     left_q <= left_d;
  end
endmodule

// File: rtl/vwt_rate_gate.sv
module vwt_rate_gate #(
  parameter int THROTTLE_RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active_q,
  input  logic active_d,
  output logic dispatch_en
);
  localparam int PW = (THROTTLE_RATIO > 1) ? $clog2(THROTTLE_RATIO) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(THROTTLE_RATIO - 1);

  logic [PW-1:0] skip_q, skip_d;
  logic          en_d;

  generate
    if (THROTTLE_RATIO <= 1) begin : g_no_skip
      assign skip_d = '0;
      assign en_d   = 1'b1;
    end else begin : g_skip
      always_comb begin
        if (!active_q)            skip_d = '0;
        else if (skip_q == PH_LAST) skip_d = '0;
        else                      skip_d = skip_q + 1'b1;
      end
      assign en_d = !active_d || (skip_d == PH_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q      <= '0;
      dispatch_en <= 1'b1;
    end else begin
      skip_q      <= skip_d;
      dispatch_en <= en_d;
    end
  end
endmodule

// File: rtl/vwarm_throttle.sv
module vwarm_throttle
  import vwt_pkg::*;
#(
  parameter int WARMUP_CYCLES  = 56000,
  parameter int IDLE_CYCLES    = 2700000,
  parameter int THROTTLE_SPAN  = 32,
  parameter int THROTTLE_RATIO = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slot_valid,
  input  logic       slot_vec_wr,
  input  logic [1:0] slot_width,
  output logic       dispatch_en,
  output logic [1:0] phase_state
);
  phase_t phase_q, phase_d;
  logic   wide_seen, trigger;
  logic   throttle_on, throttle_next;

  // A slot counts as wide only when valid and its effective width is 256 or more.
  assign wide_seen = slot_valid && is_wide(slot_width);
  // Only a vector-writing slot seen while warming opens the throttle window.
  assign trigger   = (phase_q == PH_TRANS) && slot_valid && (slot_vec_wr || is_wide(slot_width));

  vwt_phase_fsm #(
    .WARMUP_CYCLES(WARMUP_CYCLES),
    .IDLE_CYCLES  (IDLE_CYCLES)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .wide_seen(wide_seen),
    .phase_q  (phase_q),
    .phase_d  (phase_d)
  );

  vwt_shadow #(
    .THROTTLE_SPAN(THROTTLE_SPAN)
  ) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .trigger (trigger),
    .phase_d (phase_d),
    .active_q(throttle_on),
    .active_d(throttle_next)
  );

  vwt_rate_gate #(
    .THROTTLE_RATIO(THROTTLE_RATIO)
  ) u_gate (
    .clk        (clk),
    .rst        (rst),
    .active_q   (throttle_on),
    .active_d   (throttle_next),
    .dispatch_en(dispatch_en)
  );

  assign phase_state = phase_q;
endmodule

// File: rtl/vwarm_throttle_chk.sv
module vwarm_throttle_chk #(
  parameter int THROTTLE_RATIO = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       slot_valid,
  input logic       slot_vec_wr,
  input logic [1:0] slot_width,
  input logic       dispatch_en,
  input logic [1:0] phase_state,
  input logic       throttle_on
);
  localparam int LW = $clog2(THROTTLE_RATIO + 2);
  logic [LW-1:0] low_run;
  logic          wide;

  assign wide = slot_valid && (slot_width >= 2'd2);

  always_ff @(posedge clk) begin
    if (rst || dispatch_en) low_run <= '0;
    else if (low_run != {LW{1'b1}}) low_run <= low_run + 1'b1;
  end

  AST_RESET_COLD: assert property (@(posedge clk) rst |=> (phase_state == 2'd0 && dispatch_en)); // R1
  AST_COLD_WAKE: assert property (@(posedge clk) disable iff (rst)
    (phase_state == 2'd0 && wide) |=> phase_state == 2'd1); // R2
  AST_COLD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase_state == 2'd0 && !wide) |=> phase_state == 2'd0); // R2
  AST_NO_SKIP_WARMUP: assert property (@(posedge clk) disable iff (rst)
    phase_state == 2'd0 |=> phase_state != 2'd2); // R3
  AST_WARM_NO_BACK: assert property (@(posedge clk) disable iff (rst)
    phase_state == 2'd2 |=> phase_state != 2'd1); // R4
  AST_WIDE_KEEPS_WARM: assert property (@(posedge clk) disable iff (rst)
    (phase_state == 2'd2 && wide) |=> phase_state == 2'd2); // R4
  AST_TRIGGER_OPENS: assert property (@(posedge clk) disable iff (rst)
    (phase_state == 2'd1 && slot_valid && slot_vec_wr) |=> (throttle_on || phase_state == 2'd2)); // R5
  AST_SKIP_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(low_run) < THROTTLE_RATIO); // R6
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    !throttle_on |-> dispatch_en); // R8
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!throttle_on && !slot_valid) |=> !throttle_on); // R8
  AST_WARM_OPEN: assert property (@(posedge clk) disable iff (rst)
    phase_state == 2'd2 |-> (dispatch_en && !throttle_on)); // R9
endmodule

bind vwarm_throttle vwarm_throttle_chk #(
  .THROTTLE_RATIO(THROTTLE_RATIO)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_valid (slot_valid),
  .slot_vec_wr(slot_vec_wr),
  .slot_width (slot_width),
  .dispatch_en(dispatch_en),
  .phase_state(phase_state),
  .throttle_on(throttle_on)
);

// File: tb/vwarm_throttle_test.sv
module vwarm_throttle_test;
  localparam int CLK_PERIOD = 10;
  localparam int WARMUP = 40;
  localparam int IDLE   = 60;
  localparam int SPAN   = 6;
  localparam int RATIO  = 4;
  localparam int NROWS  = 25;

  // Row: {valid, vec_wr, width[1:0], expected state[1:0], expected dispatch_en}
  localparam logic [6:0] TBL [NROWS] = '{
    7'b0_0_11_00_1, 7'b1_1_01_00_1, 7'b1_1_00_00_1, 7'b1_0_00_00_1,
    7'b1_1_10_01_1, 7'b1_0_00_01_1, 7'b0_1_01_01_1, 7'b1_1_00_01_0,
    7'b1_0_00_01_0, 7'b1_0_00_01_0, 7'b1_0_00_01_1, 7'b1_0_00_01_0,
    7'b1_0_00_01_0, 7'b1_0_00_01_1, 7'b1_0_00_01_1, 7'b1_1_01_01_0,
    7'b0_0_00_01_0, 7'b1_1_00_01_0, 7'b0_0_00_01_1, 7'b0_0_00_01_0,
    7'b0_0_00_01_0, 7'b0_0_00_01_0, 7'b0_0_00_01_1, 7'b0_0_00_01_1,
    7'b0_0_00_01_1
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slot_valid = 1'b0;
  logic       slot_vec_wr = 1'b0;
  logic [1:0] slot_width = 2'd0;
  logic       dispatch_en;
  logic [1:0] phase_state;
  int         n_checks = 0;
  int         n_fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vwarm_throttle #(
    .WARMUP_CYCLES (WARMUP),
    .IDLE_CYCLES   (IDLE),
    .THROTTLE_SPAN (SPAN),
    .THROTTLE_RATIO(RATIO)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .slot_valid (slot_valid),
    .slot_vec_wr(slot_vec_wr),
    .slot_width (slot_width),
    .dispatch_en(dispatch_en),
    .phase_state(phase_state)
  );

  task automatic step(input logic v, input logic wr, input logic [1:0] w);
    slot_valid  = v;
    slot_vec_wr = wr;
    slot_width  = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0);
  endtask

  task automatic check(input string req, input logic [1:0] st, input logic en);
    n_checks++;
    if (phase_state !== st || dispatch_en !== en) begin
      n_fails++;
      $display("FAIL %s: actual state=%0d en=%0b expected state=%0d en=%0b",
               req, phase_state, dispatch_en, st, en);
    end
  endtask

  function automatic string row_req(input int i);
    if (i < 4)  return "R2";
    if (i == 4) return "R5";
    if (i < 7)  return "R8";
    if (i < 15) return "R6";
    return "R7";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", 2'd0, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      step(TBL[i][6], TBL[i][5], TBL[i][4:3]);
      check(row_req(i), TBL[i][2:1], TBL[i][0]);
    end

    // Transition entered at row 4; warm is due on the 40th step after it (step 44).
    idle(16);                                 // steps 25..40
    step(1'b1, 1'b1, 2'd0); check("R5", 2'd1, 1'b0);   // step 41
    step(1'b1, 1'b0, 2'd0); check("R6", 2'd1, 1'b0);   // step 42
    step(1'b1, 1'b0, 2'd0); check("R3", 2'd1, 1'b0);   // step 43
    step(1'b1, 1'b0, 2'd0); check("R9", 2'd2, 1'b1);   // step 44
    idle(5);                                  // steps 45..49
    step(1'b1, 1'b1, 2'd2); check("R4", 2'd2, 1'b1);   // step 50, idle count restarts
    step(1'b1, 1'b1, 2'd1); check("R8", 2'd2, 1'b1);   // step 51
    idle(57);                                 // steps 52..108
    step(1'b0, 1'b0, 2'd0); check("R4", 2'd2, 1'b1);   // step 109
    step(1'b0, 1'b0, 2'd0); check("R4", 2'd0, 1'b1);   // step 110
    step(1'b1, 1'b1, 2'd3); check("R2", 2'd1, 1'b1);   // 512-bit wakes
    step(1'b1, 1'b1, 2'd0); check("R5", 2'd1, 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b0, 2'd0); check("R1", 2'd0, 1'b1);
    rst = 1'b0;
    step(1'b0, 1'b0, 2'd0); check("R1", 2'd0, 1'b1);

    // Pure timing from a fresh wake.
    step(1'b1, 1'b0, 2'd2); check("R2", 2'd1, 1'b1);
    idle(WARMUP - 1);       check("R3", 2'd1, 1'b1);
    idle(1);                check("R3", 2'd2, 1'b1);
    idle(IDLE - WARMUP - 1); check("R4", 2'd2, 1'b1);
    idle(1);                check("R4", 2'd0, 1'b1);
    step(1'b1, 1'b1, 2'd1); check("R8", 2'd0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule